// File: doc/BRIEF.md
# External Bus Access Timer

This block times every bus access of a small controller-style bus. A requester raises `req` for one clock together with a region code and a read/write flag. The block then holds `busy` for the whole access and drives an active-low read or write strobe in a programmed window. It pulses `done` in the final cycle. Region codes 0 to 3 select one of four external spaces. Codes 4 and 5 select internal ROM/RAM, and codes 6 and 7 select the special-function register area.

Each external space has an 8-bit timing word. Bits [4:3] hold the setup length minus one: this is the number of clocks from the start of the access to the strobe falling. Bits [2:0] hold the strobe-low length in clocks. Bit 6 adds a recovery clock after the strobe rises. Only a sparse set of codes is legal, and a smaller set is legal when the bus runs in multiplexed mode. An illegal code runs at the reset timing and sets a sticky error flag. Internal accesses never drive the strobes. Their length depends only on the two wait-mode inputs.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset, all four timing words read back as 8'h03. `rd_n` and `wr_n` are 1, and `busy`, `done` and `cfg_err` are 0.
- R2: A write with `cfg_we`=1 updates the word chosen by `cfg_addr`. Bits 6 and [4:0] are stored, while bits 7 and 5 are dropped and read back as 0. `cfg_rdata` shows the word chosen by `cfg_addr`.
- R3: An external access has setup length F = bits[4:3]+1 and strobe length S = bits[2:0]. With cycle 1 being the clock after acceptance, the strobe is low in cycles F+1 through F+S and high otherwise. The strobe is `rd_n` when `rw`=1 and `wr_n` when `rw`=0, and the reset word gives 1+3.
- R4: With `mux_mode`=0 the legal codes (bits[4:0]) are 00001 to 00110, 01010 to 01101 and 10011 to 10110, and each runs exactly as R3 gives.
- R5: With `mux_mode`=1 the only legal codes are 01010 to 01101 and 10011 to 10101.
- R6: An illegal code for the current mode runs as 1+3, and bit 6 is still honoured. Starting such an access sets `cfg_err`, which stays 1 until reset.
- R7: When bit 6 is 1, one recovery cycle (cycle F+S+1) follows the strobe. In that cycle both strobes are high and `busy` is 1, and `done` moves to that cycle.
- R8: Regions 4 and 5 take 1 cycle, or 2 when `mem_wait`=1, and neither strobe falls.
- R9: Regions 6 and 7 take 2 cycles, or 3 when `sfr_wait`=1, and neither strobe falls.
- R10: `req` is accepted at a clock edge where `busy`=0, and `busy` is 1 from the next cycle. `done` is 1 for exactly the last cycle, and `busy` is 0 in the cycle after it. A `req` raised while `busy`=1 is ignored.
- R11: The timing word, mode inputs and direction are captured when the access is accepted. A write to the same word during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing-word write enable |
| cfg_addr | input | 2 | Timing-word index for write and readback |
| cfg_wdata | input | 8 | Timing-word write data |
| cfg_rdata | output | 8 | Readback of the indexed timing word |
| req | input | 1 | Access request, one clock |
| region | input | 3 | 0-3 external space, 4-5 internal memory, 6-7 register area |
| rw | input | 1 | 1 = read, 0 = write |
| mem_wait | input | 1 | Adds one wait to internal memory accesses |
| sfr_wait | input | 1 | Adds one wait to register-area accesses |
| mux_mode | input | 1 | Multiplexed-bus legality rules |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| cfg_err | output | 1 | Sticky illegal-code flag |

## Verification
Every output is registered from the next state, so everything the access does is due in the cycles counted from the clock edge that accepts `req`. The strobe-low window falls in cycles F+1 to F+S, `done` falls in cycle F+S (or F+S+1 with recovery), `busy` drops one cycle later, and `cfg_err` is set from cycle 1. The bench drives and samples on the falling edge. It compares all four handshake/strobe outputs against a per-cycle prediction for every cycle of every access, plus the cycle after it. A readback is due in the cycle after the write edge.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int CFG_W       = 8;
  localparam int FIELD_W     = 2;
  localparam int SECOND_W    = 3;
  localparam int FIELD_LSB   = 3;
  localparam int SECOND_LSB  = 0;
  localparam int REC_BIT     = 6;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h03;
  localparam logic [CFG_W-1:0] CFG_KEEP  = 8'h5F;
  // longest access: 4 setup + 7 strobe + 1 recovery
  localparam int MAX_CYCLES  = (1 << FIELD_W) + (1 << SECOND_W) - 1 + 1;
  localparam int CNT_W       = $clog2(MAX_CYCLES + 1);

  typedef struct packed {
    logic [FIELD_W-1:0]  first;
    logic [SECOND_W-1:0] second;
    logic                recover;
    logic                bad;
  } timing_t;
endpackage

// File: rtl/bct_cfg_regs.sv
module bct_cfg_regs
  import bct_pkg::*;
#(
  parameter int NUM_SPACES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_SPACES)-1:0] wr_sel,
  input  logic [CFG_W-1:0]              wr_data,
  output logic [CFG_W-1:0]              rd_data,
  input  logic [$clog2(NUM_SPACES)-1:0] acc_sel,
  output logic [CFG_W-1:0]              acc_word
);
  localparam int SEL_W = $clog2(NUM_SPACES);

  logic [CFG_W-1:0] words [NUM_SPACES];

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= CFG_RESET;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        words[g] <= wr_data & CFG_KEEP;
    end
  end

  assign rd_data  = words[wr_sel];
  assign acc_word = words[acc_sel];

  assert_dropped_bits_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((words[$past(wr_sel)] & ~CFG_KEEP) == '0));
endmodule

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
(
  input  logic [CFG_W-1:0] word,
  input  logic             mux,
  output timing_t          tim
);
  logic [FIELD_W-1:0]  fld;
  logic [SECOND_W-1:0] sec;
  logic                sep_ok;
  logic                mux_ok;
  logic                ok;

  always_comb begin
    fld    = word[FIELD_LSB +: FIELD_W];
    sec    = word[SECOND_LSB +: SECOND_W];
    sep_ok = ((fld == 2'd0) && (sec >= 3'd1) && (sec <= 3'd6)) ||
             ((fld == 2'd1) && (sec >= 3'd2) && (sec <= 3'd5)) ||
             ((fld == 2'd2) && (sec >= 3'd3) && (sec <= 3'd6));
    mux_ok = sep_ok && (fld != 2'd0) && (sec <= 3'd5);
    ok     = mux ? mux_ok : sep_ok;
    tim.first   = ok ? (fld + 2'd1) : 2'd1;
    tim.second  = ok ? sec : 3'd3;
    tim.recover = word[REC_BIT];
    tim.bad     = ~ok;
  end
endmodule

// File: rtl/bct_seq.sv
module bct_seq
  import bct_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] ld_first,
  input  logic [CNT_W-1:0] ld_body,
  input  logic [CNT_W-1:0] ld_end,
  input  logic             ld_ext,
  input  logic             ld_read,
  output logic             rd_n,
  output logic             wr_n,
  output logic             busy,
  output logic             done
);
  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] first_q, first_n;
  logic [CNT_W-1:0] body_q, body_n;
  logic [CNT_W-1:0] end_q, end_n;
  logic             ext_q, ext_n;
  logic             read_q, read_n;
  logic             low_n;
  logic             rd_n_q, wr_n_q, done_q;

  always_comb begin
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    first_n = first_q;
    body_n  = body_q;
    end_n   = end_q;
    ext_n   = ext_q;
    read_n  = read_q;
    if (start) begin
      busy_n  = 1'b1;
      cnt_n   = CNT_W'(1);
      first_n = ld_first;
      body_n  = ld_body;
      end_n   = ld_end;
      ext_n   = ld_ext;
      read_n  = ld_read;
    end else if (busy_q) begin
      if (cnt_q == end_q) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
    low_n = busy_n && ext_n && (cnt_n > first_n) && (cnt_n <= body_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      first_q <= '0;
      body_q  <= '0;
      end_q   <= '0;
      ext_q   <= 1'b0;
      read_q  <= 1'b0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      cnt_q   <= cnt_n;
      first_q <= first_n;
      body_q  <= body_n;
      end_q   <= end_n;
      ext_q   <= ext_n;
      read_q  <= read_n;
      rd_n_q  <= ~(low_n && read_n);
      wr_n_q  <= ~(low_n && !read_n);
      done_q  <= busy_n && (cnt_n == end_n);
    end
  end

  assign rd_n = rd_n_q;
  assign wr_n = wr_n_q;
  assign busy = busy_q;
  assign done = done_q;

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_strobe_in_access_R3: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> busy);
  assert_no_overlap_start_R10: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_done_inside_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_release_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  assert_hold_until_done_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  assert_recovery_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (done && ext_q && (end_q != body_q)) |-> (rd_n && wr_n));
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import bct_pkg::*;
#(
  parameter int NUM_SPACES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [$clog2(NUM_SPACES)-1:0] cfg_addr,
  input  logic [CFG_W-1:0]              cfg_wdata,
  output logic [CFG_W-1:0]              cfg_rdata,
  input  logic                          req,
  input  logic [$clog2(NUM_SPACES):0]   region,
  input  logic                          rw,
  input  logic                          mem_wait,
  input  logic                          sfr_wait,
  input  logic                          mux_mode,
  output logic                          rd_n,
  output logic                          wr_n,
  output logic                          busy,
  output logic                          done,
  output logic                          cfg_err
);
  localparam int SEL_W = $clog2(NUM_SPACES);

  logic [CFG_W-1:0] acc_word;
  timing_t          tim;
  logic             ext;
  logic             is_sfr;
  logic             accept;
  logic [CNT_W-1:0] n_int;
  logic [CNT_W-1:0] ext_body;
  logic [CNT_W-1:0] ld_first, ld_body, ld_end;
  logic             err_q;

  bct_cfg_regs #(.NUM_SPACES(NUM_SPACES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_addr),
    .wr_data  (cfg_wdata),
    .rd_data  (cfg_rdata),
    .acc_sel  (region[SEL_W-1:0]),
    .acc_word (acc_word)
  );

  bct_decode u_dec (
    .word (acc_word),
    .mux  (mux_mode),
    .tim  (tim)
  );

  always_comb begin
    ext      = ~region[SEL_W];
    is_sfr   = region[SEL_W-1];
    accept   = req && !busy;
    if (is_sfr) n_int = sfr_wait ? CNT_W'(3) : CNT_W'(2);
    else        n_int = mem_wait ? CNT_W'(2) : CNT_W'(1);
    ext_body = CNT_W'(tim.first) + CNT_W'(tim.second);
    ld_first = ext ? CNT_W'(tim.first) : n_int;
    ld_body  = ext ? ext_body : n_int;
    ld_end   = ext ? (ext_body + CNT_W'(tim.recover)) : n_int;
  end

  bct_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .ld_first (ld_first),
    .ld_body  (ld_body),
    .ld_end   (ld_end),
    .ld_ext   (ext),
    .ld_read  (rw),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .busy     (busy),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else if (accept && ext && tim.bad)
      err_q <= 1'b1;
  end

  assign cfg_err = err_q;

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);
  assert_internal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !busy && region[SEL_W]) |=> (rd_n && wr_n));
endmodule

// File: tb/bus_cycle_timer_test.sv
module bus_cycle_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       req = 1'b0;
  logic [2:0] region = '0;
  logic       rw = 1'b1;
  logic       mem_wait = 1'b0;
  logic       sfr_wait = 1'b0;
  logic       mux_mode = 1'b0;
  logic       rd_n, wr_n, busy, done, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int wr_at = 0;
  logic [7:0] mid_data = '0;

  always #5 clk = ~clk;

  bus_cycle_timer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .region(region),
    .rw(rw), .mem_wait(mem_wait), .sfr_wait(sfr_wait), .mux_mode(mux_mode),
    .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  // {code, mux, rw, first, second, rec, bad}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b1, 2'd1, 3'd1, 1'b0, 1'b0},
    {8'h06, 1'b0, 1'b0, 2'd1, 3'd6, 1'b0, 1'b0},
    {8'h0A, 1'b0, 1'b1, 2'd2, 3'd2, 1'b0, 1'b0},
    {8'h0D, 1'b0, 1'b0, 2'd2, 3'd5, 1'b0, 1'b0},
    {8'h16, 1'b0, 1'b1, 2'd3, 3'd6, 1'b0, 1'b0},
    {8'h53, 1'b0, 1'b0, 2'd3, 3'd3, 1'b1, 1'b0},
    {8'hA2, 1'b0, 1'b1, 2'd1, 3'd2, 1'b0, 1'b0},
    {8'h0C, 1'b1, 1'b0, 2'd2, 3'd4, 1'b0, 1'b0},
    {8'h55, 1'b1, 1'b1, 2'd3, 3'd5, 1'b1, 1'b0},
    {8'h0E, 1'b0, 1'b0, 2'd1, 3'd3, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1, 2'd1, 3'd3, 1'b0, 1'b1},
    {8'h16, 1'b1, 1'b0, 2'd1, 3'd3, 1'b0, 1'b1},
    {8'h03, 1'b1, 1'b1, 2'd1, 3'd3, 1'b0, 1'b1},
    {8'h4E, 1'b0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic write_cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // first: setup clocks (internal: n, with second = 0); inj: cycle to raise req
  task automatic run_access(input logic [2:0] reg_i, input logic rw_i,
                            input int first, input int second, input int rec,
                            input int inj, input string tag);
    int last;
    last = first + second + rec;
    @(negedge clk);
    region = reg_i; rw = rw_i; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= last + 1; k++) begin
      logic low;
      logic [3:0] exp_v, act_v;
      low   = (k > first) && (k <= first + second);
      exp_v = {~(low & rw_i), ~(low & ~rw_i), 1'(k <= last), 1'(k == last)};
      act_v = {rd_n, wr_n, busy, done};
      check(act_v == exp_v, tag, $sformatf("cycle %0d {rd_n,wr_n,busy,done}", k),
            int'(act_v), int'(exp_v));
      req = (k == inj);
      if (k == wr_at) begin
        cfg_we = 1'b1; cfg_wdata = mid_data;
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    req = 1'b0;
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic err_exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({rd_n, wr_n, busy, done, cfg_err} == 5'b11000, "R1", "outputs",
          int'({rd_n, wr_n, busy, done, cfg_err}), 'h18);
    for (int i = 0; i < 4; i++) begin
      cfg_addr = 2'(i);
      #1;
      check(cfg_rdata == 8'h03, "R1", $sformatf("word %0d", i), cfg_rdata, 8'h03);
    end
    // R3 default timing, read and write
    run_access(3'd2, 1'b1, 1, 3, 0, 0, "R3");
    run_access(3'd3, 1'b0, 1, 3, 0, 0, "R3");
    // R8 internal memory
    mem_wait = 1'b0; run_access(3'd4, 1'b1, 1, 0, 0, 0, "R8");
    mem_wait = 1'b1; run_access(3'd5, 1'b0, 2, 0, 0, 0, "R8");
    // R9 register area
    sfr_wait = 1'b0; run_access(3'd6, 1'b1, 2, 0, 0, 0, "R9");
    sfr_wait = 1'b1; run_access(3'd7, 1'b0, 3, 0, 0, 0, "R9");
    // R10 request during busy ignored
    run_access(3'd0, 1'b1, 1, 3, 0, 2, "R10");
    repeat (3) begin
      check(busy == 1'b0, "R10", "busy after ignored req", busy, 0);
      @(negedge clk);
    end
    // R11 mid-access write affects only the next access
    write_cfg(2'd1, 8'h16);
    cfg_addr = 2'd1; mid_data = 8'h01; wr_at = 2;
    run_access(3'd1, 1'b1, 3, 6, 0, 0, "R11");
    wr_at = 0;
    run_access(3'd1, 1'b0, 1, 1, 0, 0, "R11");
    check(cfg_err == 1'b0, "R6", "err before illegal", cfg_err, 0);
    // vector table: R2, R4, R5, R6, R7
    err_exp = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] code;
      logic m, d, rec, bad;
      int f, s;
      string tag;
      {code, m, d} = VEC[i][16:7];
      f   = int'(VEC[i][6:5]);
      s   = int'(VEC[i][4:2]);
      rec = VEC[i][1];
      bad = VEC[i][0];
      write_cfg(2'(i % 4), code);
      #1;
      check(cfg_rdata == (code & 8'h5F), "R2", "readback", cfg_rdata, code & 8'h5F);
      mux_mode = m;
      tag = bad ? "R6" : (rec ? "R7" : (m ? "R5" : "R4"));
      run_access(3'(i % 4), d, f, s, int'(rec), 0, tag);
      err_exp = err_exp | bad;
      check(cfg_err == err_exp, "R6", "sticky err", cfg_err, err_exp);
    end
    // R6 cleared only by reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    cfg_addr = 2'd1;
    #1;
    check(cfg_err == 1'b0, "R6", "err after reset", cfg_err, 0);
    check(cfg_rdata == 8'h03, "R1", "word after reset", cfg_rdata, 8'h03);
    finish_up();
  end
endmodule